// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

The block is a watchdog for a small processor core. It runs from a slow free-running internal clock. A prescale counter divides that clock into a base tick. A postscale counter then counts base ticks until it reaches a power-of-two threshold, which a 4-bit period select chooses. Software must keep restarting the count with a clear strobe. If the count expires, the block reports a timeout.

A hardware-fuse enable switches the watchdog on permanently. When the fuse is off, a software enable switches it on instead. The enabled state also keeps the feeding oscillator running. Both counters return to zero on several events:

- a software clear strobe
- the core dropping into sleep
- any change of the oscillator frequency-select bits
- a clock-failure indication
- any device reset

A timeout normally becomes a one-cycle device-reset request. When the core is asleep, it becomes a one-cycle wake-up request instead. A sticky flag tells software that the last reset was caused by the watchdog.

Top module: `wdog_timer`

## Requirements
- R1: A base tick occurs every PRE_DIV clock cycles, with PRE_DIV defaulting to 128. The timeout fires after PRE_DIV * 2^sel cycles, counted from the clock edge that last cleared or enabled the counters. `per_sel_i` = sel, so sel = 0..15 gives ratios 1:1 to 1:32768.
- R2: After a timeout both counters restart from zero. While nothing else intervenes, further timeouts follow every PRE_DIV * 2^sel cycles.
- R3: With `fuse_en_i` = 1 the watchdog runs and `sw_en_i` has no effect. With `fuse_en_i` = 0, `sw_en_i` alone enables it.
- R4: While disabled, the counters are held at zero and neither `wdt_rst_o` nor `wake_o` is ever asserted.
- R5: `osc_en_o` is 1 exactly while the watchdog is enabled.
- R6: A one-cycle `clr_i` pulse restarts the full period from the edge that samples it.
- R7: A rising edge of `sleep_i` restarts the count. A timeout while `sleep_i` = 1 raises `wake_o` and not `wdt_rst_o`.
- R8: Any change in `fsel_i` from its value in the previous cycle restarts the count.
- R9: A cycle with `clk_fail_i` = 1 or `dev_rst_i` = 1 restarts the count.
- R10: `wdt_rst_o` and `wake_o` are registered pulses of exactly one cycle. They are high in the cycle after the edge that ends the period, and they are never high together.
- R11: Changing `per_sel_i` does not clear the counters. The new threshold is used from the next base tick. If the count already meets or exceeds the new threshold, the timeout fires on that tick.
- R12: `to_flag_o` is set together with `wdt_rst_o`. It is cleared by `rst_ni` or `clr_i`. It is not changed by `dev_rst_i` or by a wake-up timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow internal clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| fuse_en_i | input | 1 | Hardware-fuse enable |
| sw_en_i | input | 1 | Software enable, used only when the fuse is off |
| per_sel_i | input | SEL_W (4) | Postscale ratio select, 2^sel |
| clr_i | input | 1 | Software clear strobe |
| sleep_i | input | 1 | Core is in sleep or a power-managed mode |
| fsel_i | input | FSEL_W (3) | Oscillator frequency-select bits |
| clk_fail_i | input | 1 | Clock-failure indication |
| dev_rst_i | input | 1 | Any device reset |
| osc_en_o | output | 1 | Keep the feeding oscillator running |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |
| wake_o | output | 1 | One-cycle wake-up request |
| to_flag_o | output | 1 | Last reset came from the watchdog |

## Verification
The assertions assume the following about the inputs:

- All inputs are synchronous to `clk_i`.
- `clr_i`, `clk_fail_i` and `dev_rst_i` are strobes.
- `fsel_i` and `sleep_i` change only between edges.

The stimulus meets these assumptions by changing every input on the falling edge only. Each clearing event is held for a single cycle. A run is stopped by disabling the watchdog, which gates any timeout in the same cycle, before the next scenario starts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic sw_clr;
    logic sleep_in;
    logic fsel_chg;
    logic clk_fail;
    logic dev_rst;
    logic off;
  } clr_src_t;

  typedef enum logic [1:0] {
    TO_NONE  = 2'd0,
    TO_RESET = 2'd1,
    TO_WAKE  = 2'd2
  } to_kind_e;

  function automatic logic any_clear(clr_src_t s);
    return s.sw_clr | s.sleep_in | s.fsel_chg | s.clk_fail | s.dev_rst | s.off;
  endfunction

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int FSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fuse_en_i,
  input  logic              sw_en_i,
  input  logic              clr_i,
  input  logic              sleep_i,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic              clk_fail_i,
  input  logic              dev_rst_i,
  output logic              en_o,
  output logic              clear_o
);
  import wdt_pkg::*;

  logic              sleep_q;
  logic [FSEL_W-1:0] fsel_q;
  clr_src_t          src;

  // fuse overrides software
  assign en_o = fuse_en_i ? 1'b1 : sw_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      fsel_q  <= '0;
    end else begin
      sleep_q <= sleep_i;
      fsel_q  <= fsel_i;
    end
  end

  always_comb begin
    src          = '0;
    src.sw_clr   = clr_i;
    src.sleep_in = sleep_i & ~sleep_q;
    src.fsel_chg = |(fsel_i ^ fsel_q);
    src.clk_fail = clk_fail_i;
    src.dev_rst  = dev_rst_i;
    src.off      = ~en_o;
  end

  assign clear_o = any_clear(src);

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PRE_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = wrap & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i || wrap) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdt_postscale.sv
module wdt_postscale #(
  parameter int PS_STAGES = 16,
  parameter int SEL_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             timeout_o
);
  localparam int CNT_W = (PS_STAGES > 1) ? PS_STAGES - 1 : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;

  // threshold 2^sel - 1 as a thermometer mask
  for (genvar k = 0; k < CNT_W; k++) begin : g_thr
    assign thr[k] = (32'(sel_i) > 32'(k));
  end

  assign timeout_o = tick_i & ~clear_i & (cnt_q >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i || timeout_o) cnt_q <= '0;
    else if (tick_i)               cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic timeout_i,
  input  logic sleep_i,
  input  logic sw_clr_i,
  output logic rst_o,
  output logic wake_o,
  output logic flag_o
);
  import wdt_pkg::*;

  to_kind_e kind;

  always_comb begin
    kind = TO_NONE;
    if (timeout_i) kind = sleep_i ? TO_WAKE : TO_RESET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_o  <= 1'b0;
      wake_o <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      rst_o  <= (kind == TO_RESET);
      wake_o <= (kind == TO_WAKE);
      if (sw_clr_i)              flag_o <= 1'b0;
      else if (kind == TO_RESET) flag_o <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int  PRE_DIV   = 128,
  parameter int  PS_STAGES = 16,
  parameter int  FSEL_W    = 3,
  localparam int SEL_W     = $clog2(PS_STAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fuse_en_i,
  input  logic              sw_en_i,
  input  logic [SEL_W-1:0]  per_sel_i,
  input  logic              clr_i,
  input  logic              sleep_i,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic              clk_fail_i,
  input  logic              dev_rst_i,
  output logic              osc_en_o,
  output logic              wdt_rst_o,
  output logic              wake_o,
  output logic              to_flag_o
);

  logic en, clear, tick, timeout;

  wdt_ctrl #(.FSEL_W(FSEL_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fuse_en_i  (fuse_en_i),
    .sw_en_i    (sw_en_i),
    .clr_i      (clr_i),
    .sleep_i    (sleep_i),
    .fsel_i     (fsel_i),
    .clk_fail_i (clk_fail_i),
    .dev_rst_i  (dev_rst_i),
    .en_o       (en),
    .clear_o    (clear)
  );

  wdt_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .tick_o  (tick)
  );

  wdt_postscale #(.PS_STAGES(PS_STAGES), .SEL_W(SEL_W)) u_post (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .tick_i    (tick),
    .sel_i     (per_sel_i),
    .timeout_o (timeout)
  );

  wdt_resp u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .timeout_i (timeout),
    .sleep_i   (sleep_i),
    .sw_clr_i  (clr_i),
    .rst_o     (wdt_rst_o),
    .wake_o    (wake_o),
    .flag_o    (to_flag_o)
  );

  assign osc_en_o = en;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fuse_en_i,
  input logic sw_en_i,
  input logic clr_i,
  input logic sleep_i,
  input logic osc_en_o,
  input logic wdt_rst_o,
  input logic wake_o,
  input logic to_flag_o
);

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_rst_o && wake_o)); // R10

  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R10

  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R10

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fuse_en_i && !sw_en_i) |=> (!wdt_rst_o && !wake_o)); // R4

  AST_FUSE_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_en_i |-> osc_en_o); // R5

  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!wdt_rst_o && !wake_o)); // R6

  AST_WAKE_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(sleep_i)); // R7

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> to_flag_o); // R12

  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !to_flag_o); // R12

endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fuse_en_i (fuse_en_i),
  .sw_en_i   (sw_en_i),
  .clr_i     (clr_i),
  .sleep_i   (sleep_i),
  .osc_en_o  (osc_en_o),
  .wdt_rst_o (wdt_rst_o),
  .wake_o    (wake_o),
  .to_flag_o (to_flag_o)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int P = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fuse_en_i = 1'b0, sw_en_i = 1'b0, clr_i = 1'b0, sleep_i = 1'b0;
  logic       clk_fail_i = 1'b0, dev_rst_i = 1'b0;
  logic [3:0] per_sel_i = '0;
  logic [2:0] fsel_i = '0;
  logic       osc_en_o, wdt_rst_o, wake_o, to_flag_o;

  always #10 clk_i = ~clk_i;

  wdog_timer #(.PRE_DIV(P)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fuse_en_i(fuse_en_i), .sw_en_i(sw_en_i),
    .per_sel_i(per_sel_i), .clr_i(clr_i), .sleep_i(sleep_i), .fsel_i(fsel_i),
    .clk_fail_i(clk_fail_i), .dev_rst_i(dev_rst_i), .osc_en_o(osc_en_o),
    .wdt_rst_o(wdt_rst_o), .wake_o(wake_o), .to_flag_o(to_flag_o)
  );

  typedef struct { int cyc; bit wake; string req; } exp_t;
  exp_t q[$];
  exp_t mon_e;
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: every pulse must match the head of the queue
  always @(negedge clk_i) begin
    if (rst_ni && !done && (wdt_rst_o || wake_o)) begin
      if (q.size() == 0) begin
        chk(0, "R4", "unexpected pulse at cycle", cyc, -1);
      end else begin
        mon_e = q.pop_front();
        chk(cyc == mon_e.cyc, mon_e.req, "R10 pulse cycle", cyc, mon_e.cyc);
        chk(wake_o == mon_e.wake, mon_e.req, "R7 pulse kind wake", int'(wake_o), int'(mon_e.wake));
        chk(wdt_rst_o == !mon_e.wake, mon_e.req, "R10 reset pin", int'(wdt_rst_o), int'(!mon_e.wake));
      end
    end
  end

  task automatic push(int c0, int s, bit wk, string req);
    exp_t e;
    e.cyc = c0 + (P << s); e.wake = wk; e.req = req;
    q.push_back(e);
  endtask

  task automatic settle(string req);
    int t;
    t = (q.size() > 0) ? q[q.size()-1].cyc + 1 : cyc;
    while (cyc < t) @(negedge clk_i);
    chk(q.size() == 0, req, "pending expected pulses", q.size(), 0);
  endtask

  task automatic stop();
    sw_en_i = 0; fuse_en_i = 0;
    repeat (3) @(negedge clk_i);
  endtask

  // start at a falling edge: returns cycle that counts as the clear edge
  task automatic start(output int c0);
    @(negedge clk_i);
    sw_en_i = 1;
    c0 = cyc;
  endtask

  // code: 0 clr, 1 clk_fail, 2 dev_rst, 3 fsel change, 4 sleep entry
  task automatic event_at(int code, output int c0);
    @(negedge clk_i);
    case (code)
      0: clr_i = 1;
      1: clk_fail_i = 1;
      2: dev_rst_i = 1;
      3: fsel_i = fsel_i + 3'd1;
      default: sleep_i = 1;
    endcase
    @(negedge clk_i);
    clr_i = 0; clk_fail_i = 0; dev_rst_i = 0;
    c0 = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    done = 1;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0, c1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(wdt_rst_o == 0 && wake_o == 0, "R10", "pulses after reset", int'(wdt_rst_o | wake_o), 0);
    chk(to_flag_o == 0, "R12", "flag after reset", int'(to_flag_o), 0);
    chk(osc_en_o == 0, "R5", "osc_en while disabled", int'(osc_en_o), 0);

    // R4: disabled, long idle, monitor flags any pulse
    repeat (60) @(negedge clk_i);
    chk(q.size() == 0, "R4", "idle queue", q.size(), 0);

    // R1 R2 R3 R5: software enable, sel=2, two periods
    per_sel_i = 4'd2;
    start(c0);
    push(c0, 2, 0, "R1"); push(c0 + (P << 2), 2, 0, "R2");
    @(negedge clk_i);
    chk(osc_en_o == 1, "R5", "osc_en while enabled", int'(osc_en_o), 1);
    settle("R2");
    chk(to_flag_o == 1, "R12", "flag after watchdog reset", int'(to_flag_o), 1);
    stop();

    // R6: clear mid-count restarts period, sel=3
    per_sel_i = 4'd3;
    start(c0);
    repeat (10) @(negedge clk_i);
    event_at(0, c1);
    push(c1, 3, 0, "R6");
    settle("R6");
    stop();

    // R8: frequency-select change restarts
    start(c0);
    repeat (9) @(negedge clk_i);
    event_at(3, c1);
    push(c1, 3, 0, "R8");
    settle("R8");
    stop();

    // R9: clock failure restarts
    start(c0);
    repeat (11) @(negedge clk_i);
    event_at(1, c1);
    push(c1, 3, 0, "R9");
    settle("R9");
    stop();

    // R9: device reset restarts; R12 flag untouched by it
    start(c0);
    repeat (12) @(negedge clk_i);
    event_at(2, c1);
    push(c1, 3, 0, "R9");
    @(negedge clk_i);
    chk(to_flag_o == 1, "R12", "flag kept over device reset", int'(to_flag_o), 1);
    settle("R9");
    stop();

    // R12: clear strobe clears flag
    event_at(0, c1);
    chk(to_flag_o == 0, "R12", "flag cleared by clr", int'(to_flag_o), 0);

    // R11: shrink threshold mid-count, no clear
    per_sel_i = 4'd4;
    start(c0);
    while (cyc < c0 + 2 * P) @(negedge clk_i);
    per_sel_i = 4'd2;
    push(c0, 2, 0, "R11");
    settle("R11");
    stop();

    // R7: sleep entry restarts; timeout gives wake, flag stays clear
    per_sel_i = 4'd2;
    event_at(0, c1);
    start(c0);
    repeat (5) @(negedge clk_i);
    event_at(4, c1);
    push(c1, 2, 1, "R7");
    settle("R7");
    chk(to_flag_o == 0, "R12", "flag after wake timeout", int'(to_flag_o), 0);
    stop();
    sleep_i = 0;
    @(negedge clk_i);

    // R3: fuse on, software bit toggling has no effect
    @(negedge clk_i);
    fuse_en_i = 1; sw_en_i = 0;
    c0 = cyc;
    push(c0, 2, 0, "R3");
    @(negedge clk_i);
    chk(osc_en_o == 1, "R5", "osc_en with fuse", int'(osc_en_o), 1);
    sw_en_i = 1;
    repeat (2) @(negedge clk_i);
    sw_en_i = 0;
    settle("R3");
    stop();
    chk(osc_en_o == 0, "R5", "osc_en after disable", int'(osc_en_o), 0);

    // R1: largest ratio, sel=15
    per_sel_i = 4'd15;
    start(c0);
    push(c0, 15, 0, "R1");
    settle("R1");
    stop();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule